// File: doc/BRIEF.md
# Three-Channel PWM Digital-to-Analog Output Unit

This block turns three stored duty values into three pulse-width-modulated pins. When each pin is followed by an external low-pass filter, it gives a simple digital-to-analog output. All three channels share one period counter. Software picks the counter length: 256 steps for 8-bit resolution or 512 steps for 9-bit resolution. A rate input chooses whether the counter advances on every supplied base tick or on every tenth tick. The two rates are therefore 10:1 apart, and in 9-bit mode each period is twice as long as in 8-bit mode.

Software writes a duty value into a holding register at any time. The channel copies it into the comparator only when a period wraps, so a new duty value can never cut a pulse short or add an extra one. Each pin can also be taken out of PWM use. It then shows a plain port bit held in the control register. A shared sequencer with two named states, TB_RUN and TB_LAST, marks the last step of each period. Its transitions are:
- STEP_ADVANCE: TB_RUN to TB_RUN on a step that does not reach the top count.
- STEP_TO_TOP: TB_RUN to TB_LAST when the next count equals the top value.
- WRAP: TB_LAST to TB_RUN on the next step. This clears the counter and loads every channel's duty value.
- RESTART: from either state to TB_RUN when the resolution setting changes. This clears the counter and loads the duty values at once.

Top module: `pwm_dac3`

## Requirements
- R1: After reset every pin is low, every channel is in port mode with its port bit at 0, resolution is 8-bit, and every duty value is 0.
- R2: A write to address 0, 1 or 2 stores wr_data[8:0] as the pending duty value of channel 0, 1 or 2. A write to address 3 sets the control register: bits [2:0] enable PWM on channels 0 to 2, bit 3 selects 9-bit resolution (1) or 8-bit resolution (0), and bits [6:4] are the port bits for channels 0 to 2.
- R3: In 8-bit mode the period is 256 counter steps. An enabled pin is high for duty[7:0] steps of each period, and duty bit 8 has no effect.
- R4: In 9-bit mode the period is 512 counter steps, and an enabled pin is high for duty[8:0] steps of each period.
- R5: With rate_slow low the counter advances once per tick. With rate_slow high it advances once every 10 ticks, so periods and high times are ten times longer.
- R6: A duty value of 0 keeps an enabled pin low for the whole period. The largest duty value (255 in 8-bit mode, 511 in 9-bit mode) leaves exactly one low step per period.
- R7: A new duty value written in the middle of a period does not change the current pulse. It takes effect from the next period onward.
- R8: Changing the resolution bit restarts the period counter at 0 and loads the pending duty values. A pin whose duty value is nonzero then rises within 4 clocks of the write.
- R9: A channel in port mode drives its port bit on its pin, one clock after the register write, and its duty value has no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Base-rate clock enable |
| rate_slow | input | 1 | 1: counter steps every 10th tick; 0: every tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0..2 duty, 3 control) |
| wr_data | input | 9 | Register write data |
| pwm_out | output | 3 | Channel pins (PWM or port bit) |

## Verification
The main function is tested with a set of duty, resolution and rate combinations. Over one full period, the bench counts each pin's high cycles and its rising edges, which checks the high time and the period length together. Zero duty and maximum duty separate the always-low case from the one-low-step case. A duty value with bit 8 set in 8-bit mode shows that the unused bit is ignored. Slow-rate vectors show the 10:1 scaling. Directed tests write a duty value mid-pulse to confirm the reload at the period boundary, toggle the resolution mid-period to confirm the counter restart, and set port mode over a nonzero duty value to confirm that the duty value is bypassed.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

    // Period sequencer states
    typedef enum logic [0:0] {
        TB_RUN  = 1'b0,   // counting below the top value
        TB_LAST = 1'b1    // counter sits on the top value
    } tb_state_t;

    localparam int unsigned CTRL_ADDR = 3;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_dac_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned DUTY_W = 9,
    parameter int unsigned ADDR_W = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DUTY_W-1:0]                wr_data,
    output logic [NUM_CH-1:0][DUTY_W-1:0]    duty_pend,
    output logic [NUM_CH-1:0]                pwm_en,
    output logic                             res9,
    output logic [NUM_CH-1:0]                port_bits
);

    // Control field positions: enables, resolution bit, then port bits.
    // The fields need 2*NUM_CH+1 data bits, which DUTY_W must cover.
    localparam int unsigned RES_BIT  = NUM_CH;
    localparam int unsigned PORT_LSB = NUM_CH + 1;

    logic ctrl_we;
    assign ctrl_we = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_duty
        logic duty_we;
        assign duty_we = wr_en && (wr_addr == ADDR_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                duty_pend[g] <= '0;
            end else if (duty_we) begin
                duty_pend[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_en    <= '0;
            res9      <= 1'b0;
            port_bits <= '0;
        end else if (ctrl_we) begin
            pwm_en    <= wr_data[NUM_CH-1:0];
            res9      <= wr_data[RES_BIT];
            port_bits <= wr_data[PORT_LSB +: NUM_CH];
        end
    end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_dac_pkg::*;
#(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned RATE_DIV = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rate_slow,
    input  logic             res9,
    output logic [CNT_W-1:0] cnt,
    output logic             load,
    output logic             res_q
);

    localparam int unsigned PRE_W    = (RATE_DIV > 1) ? $clog2(RATE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(RATE_DIV - 1);
    localparam logic [CNT_W-1:0] TOP_LO   = CNT_W'((1 << (CNT_W - 1)) - 1);
    localparam logic [CNT_W-1:0] TOP_HI   = {CNT_W{1'b1}};

    tb_state_t        state, state_nxt;
    logic [PRE_W-1:0] pre;
    logic             step;
    logic             restart;
    logic [CNT_W-1:0] top;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] cnt_nxt;

    // Prescaler for the slow rate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre <= '0;
        end else if (tick) begin
            pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
        end
    end

    assign step    = tick && (!rate_slow || (pre == PRE_LAST));
    assign restart = (res9 != res_q);
    assign top     = res_q ? TOP_HI : TOP_LO;
    assign cnt_inc = cnt + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TB_RUN;
            cnt   <= '0;
            res_q <= 1'b0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            res_q <= res9;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        load      = 1'b0;
        if (restart) begin
            // RESTART
            state_nxt = TB_RUN;
            cnt_nxt   = '0;
            load      = 1'b1;
        end else begin
            unique case (state)
                TB_RUN: begin
                    if (step) begin
                        cnt_nxt = cnt_inc;
                        if (cnt_inc == top) begin
                            state_nxt = TB_LAST;   // STEP_TO_TOP
                        end
                    end
                end
                TB_LAST: begin
                    if (step) begin
                        state_nxt = TB_RUN;        // WRAP
                        cnt_nxt   = '0;
                        load      = 1'b1;
                    end
                end
                default: begin
                    state_nxt = TB_RUN;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
    parameter int unsigned DUTY_W = 9,
    parameter int unsigned CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              res9,
    input  logic              load,
    input  logic [DUTY_W-1:0] duty_pend,
    input  logic              pwm_en,
    input  logic              port_bit,
    output logic [DUTY_W-1:0] duty_act,
    output logic              pin
);

    logic cmp_hi;

    // Active duty value only changes on a period boundary or restart
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_act <= '0;
        end else if (load) begin
            duty_act <= duty_pend;
        end
    end

    // Compare with full width in 9-bit mode, drop the top bit in 8-bit mode
    always_comb begin
        if (res9) begin
            cmp_hi = (DUTY_W'(cnt) < duty_act);
        end else begin
            cmp_hi = (cnt[CNT_W-2:0] < duty_act[DUTY_W-2:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else begin
            pin <= pwm_en ? cmp_hi : port_bit;
        end
    end

endmodule

// File: rtl/pwm_dac3.sv
module pwm_dac3 #(
    parameter int unsigned NUM_CH   = 3,
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned RATE_DIV = 10,
    parameter int unsigned ADDR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rate_slow,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int unsigned DUTY_W = CNT_W;

    logic [NUM_CH-1:0][DUTY_W-1:0] duty_pend;
    logic [NUM_CH-1:0][DUTY_W-1:0] duty_act;
    logic [NUM_CH-1:0]             pwm_en;
    logic [NUM_CH-1:0]             port_bits;
    logic                          res9;
    logic                          res_q;
    logic [CNT_W-1:0]              cnt;
    logic                          load;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .DUTY_W (DUTY_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .duty_pend (duty_pend),
        .pwm_en    (pwm_en),
        .res9      (res9),
        .port_bits (port_bits)
    );

    pwm_timebase #(
        .CNT_W    (CNT_W),
        .RATE_DIV (RATE_DIV)
    ) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rate_slow (rate_slow),
        .res9      (res9),
        .cnt       (cnt),
        .load      (load),
        .res_q     (res_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(
            .DUTY_W (DUTY_W),
            .CNT_W  (CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .cnt       (cnt),
            .res9      (res_q),
            .load      (load),
            .duty_pend (duty_pend[g]),
            .pwm_en    (pwm_en[g]),
            .port_bit  (port_bits[g]),
            .duty_act  (duty_act[g]),
            .pin       (pwm_out[g])
        );
    end

endmodule

// File: rtl/pwm_dac3_chk.sv
module pwm_dac3_chk #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned CNT_W  = 9
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NUM_CH-1:0]               pin,
    input logic [NUM_CH-1:0]               mode,
    input logic [NUM_CH-1:0]               port,
    input logic                            res_q,
    input logic [CNT_W-1:0]                cnt,
    input logic                            load,
    input logic [NUM_CH-1:0][CNT_W-1:0]    act
);

    localparam logic [CNT_W-1:0] TOP_LO = CNT_W'((1 << (CNT_W - 1)) - 1);

    logic was_in_reset;
    always_ff @(posedge clk) begin
        was_in_reset <= !rst_n;
    end

    always @(posedge clk) begin
        if (was_in_reset === 1'b1 && rst_n === 1'b1) begin
            AST_RESET_PINS_LOW: assert (pin == '0); // R1
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_q |-> (cnt <= TOP_LO)); // R3

    AST_DUTY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act)); // R7

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ast
        AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[g] && act[g] == '0) |=> !pin[g]); // R6

        AST_MAX_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (mode[g] && !res_q && act[g][CNT_W-2:0] == TOP_LO[CNT_W-2:0] && cnt == TOP_LO)
            |=> !pin[g]); // R6

        AST_PORT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            !mode[g] |=> (pin[g] == $past(port[g]))); // R9
    end

endmodule

bind pwm_dac3 pwm_dac3_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (pwm_out),
    .mode  (pwm_en),
    .port  (port_bits),
    .res_q (res_q),
    .cnt   (cnt),
    .load  (load),
    .act   (duty_act)
);

// File: tb/test_pwm_dac3.sv
module test_pwm_dac3;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;
    // Table: resolution (1 = 9-bit), slow rate, channel, duty, requirement tag
    localparam int V_RES [NV] = '{0, 0, 0, 0, 1, 1, 0, 1, 0};
    localparam int V_SLW [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 0};
    localparam int V_CH  [NV] = '{0, 1, 2, 0, 1, 2, 0, 1, 0};
    localparam int V_DTY [NV] = '{128, 1, 255, 0, 300, 511, 37, 5, 320};
    localparam string V_REQ [NV] = '{"R3", "R3", "R6", "R6", "R4", "R6", "R5", "R5", "R3"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       rate_slow = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic [2:0] pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_dac3 i_pwm_dac3 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rate_slow (rate_slow),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pwm_out   (pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 2'(addr);
        wr_data = 9'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Count high samples and rising edges over a window of len cycles
    task automatic measure(input int ch, input int len, output int high, output int rises);
        logic prev;
        high  = 0;
        rises = 0;
        @(negedge clk);
        prev = pwm_out[ch];
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) high++;
            if (!prev && pwm_out[ch]) rises++;
            prev = pwm_out[ch];
        end
    endtask

    task automatic wait_rise(input int ch, input int limit, output bit found);
        logic prev;
        found = 0;
        @(negedge clk);
        prev = pwm_out[ch];
        for (int k = 0; k < limit; k++) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) begin
                found = 1;
                break;
            end
            prev = pwm_out[ch];
        end
    endtask

    // Length of the current high pulse of channel 0; optional duty write at sample 10
    task automatic high_run(input bit inject, input int new_duty, output int run);
        run = 1;
        for (int k = 1; k < 2000; k++) begin
            @(negedge clk);
            if (inject && k == 10) begin
                wr_en = 1'b1; wr_addr = 2'd0; wr_data = 9'(new_duty);
            end else if (inject && k == 11) begin
                wr_en = 1'b0;
            end
            if (!pwm_out[0]) break;
            run++;
        end
        wr_en = 1'b0;
    endtask

    initial begin
        int  hi, rs, per, exp_hi, d_eff, run;
        bit  found;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(pwm_out == 3'b000, "R1 pins during reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        check(pwm_out == 3'b000, "R1 pins after reset", int'(pwm_out), 0);

        // Table walk: high time and period of one channel per vector (R2..R6)
        for (int v = 0; v < NV; v++) begin
            rate_slow = V_SLW[v][0];
            reg_write(3, 7 | (V_RES[v] << 3));
            reg_write(V_CH[v], V_DTY[v]);
            per   = (V_RES[v] ? 512 : 256) * (V_SLW[v] ? 10 : 1);
            d_eff = V_RES[v] ? V_DTY[v] : (V_DTY[v] & 255);
            exp_hi = d_eff * (V_SLW[v] ? 10 : 1);
            repeat (2 * per) @(negedge clk);
            measure(V_CH[v], per, hi, rs);
            check(hi == exp_hi, $sformatf("%s high time vector %0d", V_REQ[v], v), hi, exp_hi);
            check(rs == ((d_eff == 0) ? 0 : 1), $sformatf("%s period vector %0d", V_REQ[v], v),
                  rs, (d_eff == 0) ? 0 : 1);
        end

        // R9: port mode ignores duty and shows the port bits
        rate_slow = 1'b0;
        reg_write(1, 128);
        reg_write(3, 7'b101_0_000);
        repeat (3) @(negedge clk);
        check(pwm_out == 3'b101, "R9 port bits on pins", int'(pwm_out), 5);
        measure(1, 256, hi, rs);
        check(hi == 0, "R9 duty has no effect in port mode", hi, 0);
        measure(0, 256, hi, rs);
        check(hi == 256, "R9 port bit held high", hi, 256);

        // R7: duty written mid-pulse applies from the next period
        reg_write(0, 64);
        reg_write(3, 7'b000_0_001);
        repeat (600) @(negedge clk);
        wait_rise(0, 600, found);
        check(found, "R7 rise found", int'(found), 1);
        high_run(1'b1, 200, run);
        check(run == 64, "R7 current pulse unchanged", run, 64);
        wait_rise(0, 600, found);
        high_run(1'b0, 0, run);
        check(run == 200, "R7 new duty next period", run, 200);

        // R8: resolution change restarts the counter at zero
        repeat (20) @(negedge clk);
        reg_write(3, 7'b000_1_001);
        found = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (pwm_out[0]) begin
                found = 1;
                break;
            end
        end
        check(found, "R8 pin rises right after restart", int'(found), 1);
        high_run(1'b0, 0, run);
        check(run == 200, "R8 first pulse after restart", run, 200);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule